// File: doc/BRIEF.md
# Three-Channel Square Tone Generator

This block produces three programmable square-wave tones for a small sound subsystem. A CPU reaches it through four write-only registers that use a single write strobe. The first three registers each hold a 6-bit period for one tone channel. The fourth register is a control word with two bits: one turns the sound on, and the other selects a chained exclusive-OR (ring) modulation between neighbouring channels. Nothing can be read back.

One prescaler is shared by all three channels. It emits a tick once every `PRESCALE` clocks. Each channel counts these ticks and flips its level after `63 - P` of them. A period value of 63 therefore stops the channel and holds its current level. The channel levels then go through the optional modulation stage and then through a global mute gate. The result appears as three registered 1-bit tone outputs, together with a registered weighted sum. The sum weights the channels 2, 3 and 4, which gives loudness steps of roughly 0, 3 and 6 dB.

Top module: `sqtone_gen`

## Requirements
- R1: A write with `wr_addr` equal to 0, 1 or 2 loads `wr_data[5:0]` into the period of channel 0, 1 or 2. Bits 7:6 of the data are ignored.
- R2: With a period P below 63, a channel's level changes only on a prescaler tick. It flips every `63 - P` ticks, so each level lasts `PRESCALE * (63 - P)` clocks and a full cycle lasts twice that.
- R3: With an active period of 63, the channel level stops changing and keeps its value, whether 0 or 1. A later write of a smaller period makes the channel run again, starting from the next tick.
- R4: A write to `wr_addr` 3 sets the control word. Bit 1 is the audible enable. While it is 0, all `tone_out` bits and `mix_out` are 0. The channel dividers keep running, and period writes are still accepted during that time.
- R5: A new period value does not reset the channel's phase or level. It takes effect when the current half-cycle ends, so that edge still arrives at the old spacing.
- R6: Control bit 0 enables ring modulation. When it is set, output 0 is level0 XOR level1, output 1 is level1 XOR level2, and output 2 is level2 unchanged. When it is clear, each output follows its own channel.
- R7: `mix_out` equals 2·`tone_out[0]` + 3·`tone_out[1]` + 4·`tone_out[2]`, and it updates in the same cycle as `tone_out`.
- R8: A synchronous reset clears all periods, the prescaler, the counters, the channel levels and the control word. Both outputs read 0 afterwards, and the block starts muted in normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Register offset: 0 to 2 select a period, 3 selects control |
| wr_data | input | DATA_W (8) | Write data |
| tone_out | output | NCH (3) | Channel outputs after modulation and mute |
| mix_out | output | MIX_W (4) | Weighted sum of the channel outputs |

## Verification
The hardest case to reach is ring modulation, because the internal channel levels cannot be seen at the ports. The bench makes them known first. Right after reset it sets every period to 63. Each channel then completes its reset-time half-cycle, flips to 1 and freezes, so the levels are known when modulation is switched on. One channel is then released to toggle on every tick, which exercises the XOR against a partner that is known to be frozen. The phase-preservation case is reached by writing a short period partway through a long half-cycle. The bench then times the next two edges against the previous edge.

// File: rtl/sqtone_pkg.sv
package sqtone_pkg;

  // Control word layout: bit 1 audible enable, bit 0 ring modulation.
  typedef struct packed {
    logic audible;
    logic ring;
  } sq_ctrl_t;

  // Lowest per-channel mix weight; channel i uses MIX_WBASE + i.
  localparam int MIX_WBASE = 2;

  function automatic int mix_max(input int nch);
    int s;
    s = 0;
    for (int i = 0; i < nch; i++) s += MIX_WBASE + i;
    return s;
  endfunction

  function automatic int mix_width(input int nch);
    return $clog2(mix_max(nch) + 1);
  endfunction

endpackage

// File: rtl/sqtone_regs.sv
module sqtone_regs
  import sqtone_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int PER_W  = 6,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NCH-1:0][PER_W-1:0] period,
  output sq_ctrl_t                  ctrl
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NCH);

  for (genvar i = 0; i < NCH; i++) begin : g_per
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
    always_ff @(posedge clk) begin
      if (rst) begin
        period[i] <= '0;
      end else if (wr_en && wr_addr == MY_ADDR) begin
        period[i] <= wr_data[PER_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en && wr_addr == CTRL_ADDR) begin
      ctrl <= sq_ctrl_t'(wr_data[1:0]);
    end
  end

endmodule

// File: rtl/sqtone_prescaler.sv
module sqtone_prescaler #(
  parameter int DIV = 512
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sqtone_channel.sv
module sqtone_channel #(
  parameter int PER_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [PER_W-1:0] per_next,
  output logic             lvl
);

  localparam logic [PER_W-1:0] PMAX = {PER_W{1'b1}};

  logic [PER_W-1:0] act_per;
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] limit;
  logic             frozen;
  logic             wrap;

  assign limit  = PMAX - act_per;
  assign frozen = (limit == '0);
  assign wrap   = (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_per <= '0;
      cnt     <= '0;
      lvl     <= 1'b0;
    end else if (tick) begin
      if (frozen) begin
        // Stopped: level held, new period sampled on every tick.
        act_per <= per_next;
        cnt     <= '0;
      end else if (wrap) begin
        act_per <= per_next;
        cnt     <= '0;
        lvl     <= ~lvl;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sqtone_mixer.sv
module sqtone_mixer
  import sqtone_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int MIX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   lvl,
  input  sq_ctrl_t         ctrl,
  output logic [NCH-1:0]   tone_out,
  output logic [MIX_W-1:0] mix_out
);

  logic [NCH-1:0]   modded;
  logic [NCH-1:0]   gated;
  logic [MIX_W-1:0] sum;

  for (genvar i = 0; i < NCH; i++) begin : g_mod
    if (i < NCH - 1) begin : g_pair
      assign modded[i] = ctrl.ring ? (lvl[i] ^ lvl[i+1]) : lvl[i];
    end else begin : g_last
      assign modded[i] = lvl[i];
    end
  end

  assign gated = modded & {NCH{ctrl.audible}};

  always_comb begin
    sum = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gated[i]) sum = sum + MIX_W'(MIX_WBASE + i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tone_out <= '0;
      mix_out  <= '0;
    end else begin
      tone_out <= gated;
      mix_out  <= sum;
    end
  end

endmodule

// File: rtl/sqtone_gen.sv
module sqtone_gen
  import sqtone_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int PER_W    = 6,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int PRESCALE = 512,
  parameter int MIX_W    = mix_width(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NCH-1:0]    tone_out,
  output logic [MIX_W-1:0]  mix_out
);

  logic [NCH-1:0][PER_W-1:0] period;
  sq_ctrl_t                  ctrl;
  logic                      pre_tick;
  logic [NCH-1:0]            chan_lvl;

  sqtone_regs #(
    .NCH(NCH), .PER_W(PER_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period(period), .ctrl(ctrl)
  );

  sqtone_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .tick(pre_tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    sqtone_channel #(.PER_W(PER_W)) u_ch (
      .clk(clk), .rst(rst), .tick(pre_tick),
      .per_next(period[i]), .lvl(chan_lvl[i])
    );
  end

  sqtone_mixer #(.NCH(NCH), .MIX_W(MIX_W)) u_mix (
    .clk(clk), .rst(rst), .lvl(chan_lvl), .ctrl(ctrl),
    .tone_out(tone_out), .mix_out(mix_out)
  );

endmodule

// File: rtl/sqtone_gen_chk.sv
module sqtone_gen_chk
  import sqtone_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int MIX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NCH-1:0]    tone_out,
  input logic [MIX_W-1:0]  mix_out,
  input logic              tick,
  input logic [NCH-1:0]    lvl
);

  logic [1:0]       ctl_sh, ctl_d;
  logic [NCH-1:0]   lvl_d;
  logic             rst_d;
  logic [NCH-1:0]   exp_mod;
  logic [MIX_W-1:0] exp_mix;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      ctl_sh <= '0;
      ctl_d  <= '0;
      lvl_d  <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(NCH)) ctl_sh <= wr_data[1:0];
      ctl_d <= ctl_sh;
      lvl_d <= lvl;
    end
  end

  always_comb begin
    exp_mix = '0;
    for (int i = 0; i < NCH; i++) begin
      if (tone_out[i]) exp_mix = exp_mix + MIX_W'(MIX_WBASE + i);
    end
    for (int i = 0; i < NCH; i++) begin
      exp_mod[i] = (i < NCH - 1) ? (lvl_d[i] ^ lvl_d[(i+1) % NCH]) : lvl_d[i];
    end
  end

  assert_mute_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !ctl_d[1] |-> (tone_out == '0 && mix_out == '0));

  assert_ring_map_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_d == 2'b11) |-> (tone_out == exp_mod));

  assert_plain_map_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_d == 2'b10) |-> (tone_out == lvl_d));

  assert_mix_weights_R7: assert property (@(posedge clk) disable iff (rst)
    mix_out == exp_mix);

  for (genvar k = 0; k < NCH; k++) begin : g_tick
    assert_level_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
      !$stable(lvl[k]) |-> $past(tick));
  end

  always_ff @(posedge clk) begin
    if (rst_d) begin
      assert_reset_clear_R8: assert (tone_out == '0 && mix_out == '0)
        else $error("outputs not cleared by reset");
    end
  end

endmodule

bind sqtone_gen sqtone_gen_chk #(
  .NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MIX_W(MIX_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tone_out(tone_out), .mix_out(mix_out),
  .tick(pre_tick), .lvl(chan_lvl)
);

// File: tb/sqtone_gen_test.sv
`timescale 1ns/1ps
module sqtone_gen_test;

  localparam int PS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] tone_out;
  logic [3:0] mix_out;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sqtone_gen #(.PRESCALE(PS)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tone_out(tone_out), .mix_out(mix_out)
  );

  // Vector table: raw period bytes for channels 0..2, expected half-period in clocks.
  localparam logic [7:0] VDATA [4][3] = '{
    '{8'd60, 8'd61, 8'd62},
    '{8'd50, 8'd40, 8'd30},
    '{8'hFD, 8'h7E, 8'd0},
    '{8'd62, 8'd58, 8'hBC}
  };
  localparam int VEXP [4][3] = '{
    '{12, 8, 4},
    '{52, 92, 132},
    '{8, 4, 252},
    '{4, 20, 12}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_edge(input int k);
    logic pv;
    int n;
    pv = tone_out[k];
    n = 0;
    while (tone_out[k] == pv && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(input int k, output int half);
    logic pv;
    int n;
    wait_edge(k);
    pv = tone_out[k];
    n = 0;
    while (tone_out[k] == pv && n < 3000) begin
      @(negedge clk);
      n++;
    end
    half = n;
  endtask

  function automatic int wsum(input logic [2:0] t);
    return 2 * int'(t[0]) + 3 * int'(t[1]) + 4 * int'(t[2]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int h;
    int n;
    bit ok;
    int toggles;
    logic pv;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(tone_out == 3'b000 && mix_out == 4'd0, "R8 reset outputs", int'(tone_out), 0);

    // R4: muted after reset even with periods programmed
    wr(2'd0, 8'd61); wr(2'd1, 8'd61); wr(2'd2, 8'd61);
    ok = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (tone_out != 3'b000 || mix_out != 4'd0) ok = 1'b0;
    end
    chk(ok, "R4 muted outputs stay zero", int'(ok), 1);

    // Table walk: R1, R2 and R7 in normal audible mode
    wr(2'd3, 8'h02);
    for (int v = 0; v < 4; v++) begin
      for (int c = 0; c < 3; c++) wr(2'(c), VDATA[v][c]);
      repeat (2 * 63 * PS + 20) @(negedge clk);
      for (int c = 0; c < 3; c++) begin
        measure(c, h);
        chk(h == VEXP[v][c], "R1/R2 half period", h, VEXP[v][c]);
      end
      ok = 1'b1;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (int'(mix_out) != wsum(tone_out)) ok = 1'b0;
      end
      chk(ok, "R7 mix weights", int'(mix_out), wsum(tone_out));
    end

    // R5: mid-cycle period change keeps the running half-cycle
    wr(2'd0, 8'd50);
    repeat (2 * 63 * PS + 20) @(negedge clk);
    wait_edge(0);
    pv = tone_out[0];
    n = 0;
    repeat (10) begin
      @(negedge clk);
      n++;
    end
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd60;
    @(negedge clk);
    n++;
    wr_en = 1'b0;
    while (tone_out[0] == pv && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n == 52, "R5 old half-cycle completes", n, 52);
    pv = tone_out[0];
    n = 0;
    while (tone_out[0] == pv && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n == 12, "R5 new period after reload", n, 12);

    // R3 / R6: freeze every channel at level 1 from a fresh reset
    do_reset();
    wr(2'd0, 8'd63); wr(2'd1, 8'd63); wr(2'd2, 8'd63);
    wr(2'd3, 8'h02);
    repeat (63 * PS + 40) @(negedge clk);
    chk(tone_out == 3'b111, "R3 frozen at one", int'(tone_out), 7);
    ok = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (tone_out != 3'b111) ok = 1'b0;
    end
    chk(ok, "R3 frozen level holds", int'(tone_out), 7);
    chk(mix_out == 4'd9, "R7 full mix", int'(mix_out), 9);

    wr(2'd3, 8'h03);
    repeat (3) @(negedge clk);
    chk(tone_out == 3'b100, "R6 ring map of 1,1,1", int'(tone_out), 4);
    chk(mix_out == 4'd4, "R6 ring mix", int'(mix_out), 4);

    wr(2'd3, 8'h01);
    repeat (3) @(negedge clk);
    chk(tone_out == 3'b000 && mix_out == 4'd0, "R4 mute in ring mode", int'(tone_out), 0);

    // R3 resume + R6 XOR with a frozen partner
    wr(2'd3, 8'h03);
    wr(2'd2, 8'd62);
    repeat (20) @(negedge clk);
    ok = 1'b1;
    toggles = 0;
    pv = tone_out[2];
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tone_out[1] != ~tone_out[2] || tone_out[0] != 1'b0) ok = 1'b0;
      if (tone_out[2] != pv) toggles++;
      pv = tone_out[2];
    end
    chk(ok, "R6 ring XOR against frozen level", int'(tone_out), 0);
    chk(toggles > 10, "R3 channel resumes after write", toggles, 25);

    // R4: a period write while muted is accepted
    wr(2'd3, 8'h00);
    wr(2'd1, 8'd60);
    repeat (60) @(negedge clk);
    wr(2'd3, 8'h02);
    measure(1, h);
    chk(h == 12, "R4 write accepted while muted", h, 12);

    // R8: mid-run reset returns to muted zero outputs
    do_reset();
    @(negedge clk);
    chk(tone_out == 3'b000 && mix_out == 4'd0, "R8 reset mid-run", int'(tone_out), 0);
    ok = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tone_out != 3'b000) ok = 1'b0;
    end
    chk(ok, "R8 control cleared to muted", int'(tone_out), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule